// File: doc/BRIEF.md
# NAND Page ECC Flow Controller

This block sits in the byte path between a NAND flash interface and a data-transfer engine. Bytes pass through unchanged on a valid/ready handshake. While they pass, the block builds a 24-bit Hamming-style check word for every 256 consecutive data bytes and pushes it into a small check-word queue. Software reads the queue through a head output and a pop strobe. The block also reports how many words the queue holds.

A command-register write clears the check engine and the queue. When it is flagged as opening a new page, it also loads the page position from the page size and the start section. A read or write start strobe opens the flow, and a stop strobe closes it.

The spare-zone mode decides what happens when the queue reaches its fill threshold or when the data zone ends:
- Free-running mode never halts at the threshold.
- Interrupt mode halts the flow, raises a ready interrupt and goes idle.
- Automatic mode halts the flow and hands control to spare-zone logic. That logic reports back with a done strobe, and the queue is cleared at that point.

Top module: `nand_ecc_flow`

## Requirements
- R1: Each check word is {2'b11, column parity[5:0], line parity[15:0]} over 256 consecutive accepted bytes (i = index 0..255 in the chunk). Line parity bit 2k+i[k] is toggled by each set data bit, for each index bit k = 0..7. Column parity bit 2m+j[m] is toggled by each set data bit j, for m = 0..2. Words are queued in arrival order, and ecc_head shows the oldest.
- R2: In free-running mode (mode 2'b00) the flow continues past the queue threshold and ends only at the end of the data zone or on stop_req. After a stop, a new start strobe resumes from the same position.
- R3: In interrupt mode (mode 2'b10), the byte that completes the threshold-th word is accepted. in_ready is low in the following cycle, ecc_rdy_irq is set, and the controller is idle.
- R4: The threshold is 2 words (512 bytes) for a small page (page_large=0) and 8 words (2048 bytes) for a large page. No byte is lost or duplicated across a halt, and out_data/out_valid carry in_data/in_valid while flowing.
- R5: cmd_wr empties the queue, discards a partial chunk and clears ecc_rdy_irq. The next word then covers the 256 bytes accepted after the write.
- R6: ecc_cnt equals the number of queued words, is 0 after reset, and drops by one per ecc_pop while non-zero.
- R7: In automatic mode (mode 2'b01), reaching the data-zone end or the threshold raises spare_req with the flow halted. spare_done while spare_req is high empties the queue and drops spare_req.
- R8: On a large page, a new page with start_sect = s makes the data zone 2048-512*s bytes, and spare_zones (ecc_cnt/2) then reads 4-s at the end of the page.
- R9: ecc_chk_en is high only while spare_req is high in a read session (opened by start_rd) and mark_byte equals 8'h00.
- R10: Mode 2'b11 behaves as free-running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command-register write pulse |
| cmd_page | input | 1 | With cmd_wr: open a new page (load position) |
| start_rd | input | 1 | Start/resume a read session |
| start_wr | input | 1 | Start/resume a write session |
| stop_req | input | 1 | Stop the flow |
| mode | input | 2 | Spare-zone mode |
| page_large | input | 1 | 1: 2048-byte page, 0: 512-byte page |
| start_sect | input | 2 | Start offset in 512-byte sections (large page) |
| in_data | input | 8 | Upstream byte |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block accepts the byte |
| out_data | output | 8 | Downstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream ready |
| ecc_pop | input | 1 | Remove the oldest check word |
| ecc_head | output | 24 | Oldest check word |
| ecc_cnt | output | 4 | Words held in the queue |
| ecc_rdy_irq | output | 1 | Ready interrupt flag |
| spare_req | output | 1 | Spare-zone phase active |
| spare_zones | output | 3 | Spare zones to handle |
| spare_done | input | 1 | Spare-zone phase finished |
| mark_byte | input | 8 | Spare-zone validity marker byte |
| ecc_chk_en | output | 1 | Check words may be verified |

## Verification
The check-word arithmetic is driven by four byte patterns: an arithmetic ramp, all ones, a walking single bit, and a quadratic scramble. Together they separate errors in line parity from errors in column parity, and the all-ones pattern exposes a wrong padding or bit order. Every start section on a large page is swept in interrupt mode, which tells a wrong data-zone length apart from a wrong fill threshold. A stop in the middle of a chunk, and a command write in the middle of a chunk, show whether the engine keeps or discards partial state. The automatic mode is run in both read and write sessions with zero and non-zero marker bytes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int CHUNK_LOG2 = 8;
  localparam int ECC_W      = 24;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_AUTO = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_RSVD = 2'b11
  } spz_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLOW  = 2'd1,
    ST_SPARE = 2'd2
  } flow_st_e;

  // fold one byte into the line parity pairs, selected by its chunk index
  function automatic logic [2*CHUNK_LOG2-1:0] line_par_step(
      input logic [2*CHUNK_LOG2-1:0] lp,
      input logic [CHUNK_LOG2-1:0]   idx,
      input logic [7:0]              b);
    logic [2*CHUNK_LOG2-1:0] r;
    logic p;
    r = lp;
    p = ^b;
    for (int k = 0; k < CHUNK_LOG2; k++) begin
      if (idx[k]) r[2*k+1] = r[2*k+1] ^ p;
      else        r[2*k]   = r[2*k]   ^ p;
    end
    return r;
  endfunction

  // column parity from the xor of all bytes of the chunk
  function automatic logic [5:0] col_par(input logic [7:0] c);
    return {c[7]^c[6]^c[5]^c[4], c[3]^c[2]^c[1]^c[0],
            c[7]^c[6]^c[3]^c[2], c[5]^c[4]^c[1]^c[0],
            c[7]^c[5]^c[3]^c[1], c[6]^c[4]^c[2]^c[0]};
  endfunction

  function automatic logic [ECC_W-1:0] ecc_word(
      input logic [7:0] col, input logic [2*CHUNK_LOG2-1:0] lp);
    return {2'b11, col_par(col), lp};
  endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fire,
  input  logic [7:0]       din,
  output logic             chunk_done,
  output logic [ECC_W-1:0] ecc_out
);
  logic [CHUNK_LOG2-1:0]   idx;
  logic [2*CHUNK_LOG2-1:0] lp, lp_nx;
  logic [7:0]              col, col_nx;

  assign lp_nx      = line_par_step(lp, idx, din);
  assign col_nx     = col ^ din;
  assign chunk_done = fire && (idx == {CHUNK_LOG2{1'b1}});
  assign ecc_out    = ecc_word(col_nx, lp_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      lp  <= '0;
      col <= '0;
    end else if (clr) begin
      idx <= '0;
      lp  <= '0;
      col <= '0;
    end else if (fire) begin
      idx <= idx + 1'b1;
      if (chunk_done) begin
        lp  <= '0;
        col <= '0;
      end else begin
        lp  <= lp_nx;
        col <= col_nx;
      end
    end
  end

  assert_idx_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && !clr) |=> (idx == '0));

endmodule

// File: rtl/ecc_fifo.sv
module ecc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 24,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_nx
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok  = push && (level != CW'(DEPTH));
  assign pop_ok   = pop && (level != '0);
  assign level_nx = level + CW'(push_ok) - CW'(pop_ok);
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      level <= level_nx;
    end
  end

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_pop_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && level != '0) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int LARGE_LOG2 = 11,
  parameter int SMALL_LOG2 = 9,
  parameter int CW         = 4,
  localparam int PW        = LARGE_LOG2 + 1,
  localparam int SW        = LARGE_LOG2 - SMALL_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_page,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic          stop_req,
  input  logic [1:0]    mode,
  input  logic          page_large,
  input  logic [SW-1:0] start_sect,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          chunk_done,
  input  logic [CW-1:0] level_nx,
  input  logic          spare_done,
  input  logic [7:0]    mark_byte,
  output logic          in_ready,
  output logic          fire,
  output logic          spare_clr,
  output logic          irq,
  output logic          spare_req,
  output logic          ecc_chk_en
);
  function automatic logic [PW-1:0] page_end_of(input logic lg);
    return lg ? PW'(1) << LARGE_LOG2 : PW'(1) << SMALL_LOG2;
  endfunction

  function automatic logic [CW-1:0] thr_of(input logic lg);
    return lg ? CW'(1) << (LARGE_LOG2 - CHUNK_LOG2)
              : CW'(1) << (SMALL_LOG2 - CHUNK_LOG2);
  endfunction

  function automatic logic [PW-1:0] pos_load_of(input logic lg, input logic [SW-1:0] s);
    return lg ? PW'(s) << SMALL_LOG2 : '0;
  endfunction

  flow_st_e        st;
  spz_mode_e       mode_e;
  logic [PW-1:0]   pos, page_end;
  logic            sess_rd;
  logic            last_byte, fill_hit;

  assign mode_e     = spz_mode_e'(mode);
  assign page_end   = page_end_of(page_large);
  assign in_ready   = (st == ST_FLOW) && out_ready;
  assign fire       = in_valid && in_ready;
  assign last_byte  = fire && ((pos + PW'(1)) == page_end);
  assign fill_hit   = chunk_done && (level_nx >= thr_of(page_large));
  assign spare_req  = (st == ST_SPARE);
  assign spare_clr  = spare_req && spare_done;
  assign ecc_chk_en = spare_req && sess_rd && (mark_byte == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pos     <= '0;
      irq     <= 1'b0;
      sess_rd <= 1'b0;
    end else begin
      if (fire) pos <= pos + PW'(1);
      if (fill_hit && mode_e == MODE_IRQ) irq <= 1'b1;
      case (st)
        ST_IDLE:
          if ((start_rd || start_wr) && pos != page_end) begin
            st      <= ST_FLOW;
            sess_rd <= start_rd;
          end
        ST_FLOW:
          if (stop_req) st <= ST_IDLE;
          else if (last_byte || fill_hit) begin
            case (mode_e)
              MODE_AUTO: st <= ST_SPARE;
              MODE_IRQ:  st <= ST_IDLE;
              default:   if (last_byte) st <= ST_IDLE;
            endcase
          end
        ST_SPARE:
          if (spare_done) st <= (pos == page_end) ? ST_IDLE : ST_FLOW;
        default: st <= ST_IDLE;
      endcase
      if (cmd_wr) begin
        irq <= 1'b0;
        if (cmd_page) begin
          pos <= pos_load_of(page_large, start_sect);
          st  <= ST_IDLE;
        end
      end
    end
  end

  assert_halt_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hit && mode_e == MODE_IRQ && !cmd_wr) |=> (!in_ready && irq));
  assert_free_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_byte && !stop_req && !cmd_wr && mode_e == MODE_FREE) |=> (st == ST_FLOW));
  assert_rsvd_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_byte && !stop_req && !cmd_wr && mode_e == MODE_RSVD) |=> (st == ST_FLOW));
  assert_spare_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && mode_e == MODE_AUTO && !stop_req && !cmd_wr) |=> (spare_req && !in_ready));

endmodule

// File: rtl/nand_ecc_flow.sv
module nand_ecc_flow
  import nand_ecc_pkg::*;
#(
  parameter int LARGE_LOG2 = 11,
  parameter int SMALL_LOG2 = 9,
  localparam int DEPTH     = 1 << (LARGE_LOG2 - CHUNK_LOG2),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int SW        = LARGE_LOG2 - SMALL_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_page,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic             stop_req,
  input  logic [1:0]       mode,
  input  logic             page_large,
  input  logic [SW-1:0]    start_sect,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  input  logic             ecc_pop,
  output logic [ECC_W-1:0] ecc_head,
  output logic [CW-1:0]    ecc_cnt,
  output logic             ecc_rdy_irq,
  output logic             spare_req,
  output logic [CW-2:0]    spare_zones,
  input  logic             spare_done,
  input  logic [7:0]       mark_byte,
  output logic             ecc_chk_en
);
  logic             fire, chunk_done, spare_clr, fifo_clr;
  logic [ECC_W-1:0] ecc_new;
  logic [CW-1:0]    level_nx;

  assign out_data    = in_data;
  assign out_valid   = in_valid && in_ready;
  assign fifo_clr    = cmd_wr || spare_clr;
  assign spare_zones = ecc_cnt[CW-1:1];

  ecc_accum u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_wr),
    .fire       (fire),
    .din        (in_data),
    .chunk_done (chunk_done),
    .ecc_out    (ecc_new)
  );

  ecc_fifo #(.DEPTH(DEPTH), .W(ECC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .push     (chunk_done),
    .din      (ecc_new),
    .pop      (ecc_pop),
    .head     (ecc_head),
    .level    (ecc_cnt),
    .level_nx (level_nx)
  );

  flow_ctrl #(.LARGE_LOG2(LARGE_LOG2), .SMALL_LOG2(SMALL_LOG2), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_page   (cmd_page),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .stop_req   (stop_req),
    .mode       (mode),
    .page_large (page_large),
    .start_sect (start_sect),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .chunk_done (chunk_done),
    .level_nx   (level_nx),
    .spare_done (spare_done),
    .mark_byte  (mark_byte),
    .in_ready   (in_ready),
    .fire       (fire),
    .spare_clr  (spare_clr),
    .irq        (ecc_rdy_irq),
    .spare_req  (spare_req),
    .ecc_chk_en (ecc_chk_en)
  );

  assert_cmd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (ecc_cnt == '0 && !ecc_rdy_irq));
  assert_spare_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_req && spare_done) |=> (ecc_cnt == '0 && !spare_req));

endmodule

// File: tb/test_nand_ecc_flow.sv
module test_nand_ecc_flow;
  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, cmd_page = 0, start_rd = 0, start_wr = 0, stop_req = 0;
  logic [1:0]  mode = 0;
  logic        page_large = 0;
  logic [1:0]  start_sect = 0;
  logic [7:0]  in_data = 0;
  logic        in_valid = 0, out_ready = 1, ecc_pop = 0, spare_done = 0;
  logic [7:0]  mark_byte = 0;
  logic        in_ready, out_valid, ecc_rdy_irq, spare_req, ecc_chk_en;
  logic [7:0]  out_data;
  logic [23:0] ecc_head;
  logic [3:0]  ecc_cnt;
  logic [2:0]  spare_zones;

  int vectors = 0, errors = 0, gidx = 0, pat = 0;

  nand_ecc_flow i_nand_ecc_flow (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] pbyte(input int p, input int g);
    case (p)
      0: return 8'((g * 7) + 3);
      1: return 8'hFF;
      2: return 8'(1 << (g % 8)) ^ 8'(g >> 8);
      default: return 8'((g * g * 13) + (g >> 3));
    endcase
  endfunction

  // check word from the bit-by-bit definition
  function automatic logic [23:0] exp_ecc(input int p, input int g0);
    logic [5:0]  cp = '0;
    logic [15:0] lp = '0;
    logic [7:0]  b;
    for (int i = 0; i < 256; i++) begin
      b = pbyte(p, g0 + i);
      for (int j = 0; j < 8; j++) begin
        if (b[j]) begin
          for (int m = 0; m < 3; m++) cp[2*m + ((j >> m) & 1)] ^= 1'b1;
          for (int k = 0; k < 8; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
        end
      end
    end
    return {2'b11, cp, lp};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic pg);
    @(negedge clk); cmd_wr = 1; cmd_page = pg;
    @(negedge clk); cmd_wr = 0; cmd_page = 0;
  endtask

  task automatic start(input logic rd);
    @(negedge clk); start_rd = rd; start_wr = !rd;
    @(negedge clk); start_rd = 0; start_wr = 0;
  endtask

  task automatic stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask

  task automatic finish_spare();
    @(negedge clk); spare_done = 1;
    @(negedge clk); spare_done = 0;
  endtask

  task automatic pop();
    @(negedge clk); ecc_pop = 1;
    @(negedge clk); ecc_pop = 0;
  endtask

  task automatic send(input int nmax, output int acc);
    acc = 0;
    while (acc < nmax) begin
      in_valid = 1;
      in_data  = pbyte(pat, gidx);
      #1;
      if (!in_ready) break;
      if (acc == 0) begin
        chk("R4 passthrough data", out_data, in_data);
        chk("R4 passthrough valid", out_valid, 1);
      end
      @(posedge clk);
      acc++; gidx++;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic check_queue(input string tag, input int n, input int base);
    for (int e = 0; e < n; e++) begin
      chk(tag, ecc_head, exp_ecc(pat, base + 256 * e));
      pop();
    end
    chk("R6 queue empty after pops", ecc_cnt, 0);
  endtask

  task automatic config_page(input logic [1:0] md, input logic lg, input logic [1:0] s);
    @(negedge clk); mode = md; page_large = lg; start_sect = s;
    cmd(1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int acc, acc2, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset count", ecc_cnt, 0);
    chk("R3 reset ready", in_ready, 0);
    chk("R3 reset irq", ecc_rdy_irq, 0);
    chk("R7 reset spare", spare_req, 0);

    // R2: free-running over a whole large page, ramp pattern
    pat = 0; config_page(2'b00, 1, 0); base = gidx;
    start(0); send(4096, acc);
    chk("R2 free page length", acc, 2048);
    chk("R6 count after page", ecc_cnt, 8);
    chk("R2 no irq in free mode", ecc_rdy_irq, 0);
    check_queue("R1 words ramp", 8, base);

    // R3/R8: interrupt mode sweep of start section, all-ones pattern
    pat = 1;
    for (int s = 0; s < 4; s++) begin
      config_page(2'b10, 1, 2'(s)); base = gidx;
      start(1); send(4096, acc);
      chk("R8 zone length", acc, 2048 - 512 * s);
      chk("R3 irq at threshold", ecc_rdy_irq, (s == 0) ? 1 : 0);
      chk("R3 ready low after halt", in_ready, 0);
      chk("R8 count", ecc_cnt, 8 - 2 * s);
      chk("R1 words ones", ecc_head, exp_ecc(pat, base));
      cmd(0);
      chk("R5 cmd clears count", ecc_cnt, 0);
      chk("R5 cmd clears irq", ecc_rdy_irq, 0);
    end

    // R4: small page threshold, walking-bit pattern
    pat = 2; config_page(2'b10, 0, 0); base = gidx;
    start(0); send(4096, acc);
    chk("R4 small threshold bytes", acc, 512);
    chk("R4 small irq", ecc_rdy_irq, 1);
    chk("R4 small count", ecc_cnt, 2);
    check_queue("R1 words walking", 2, base);

    // R2: stop in mid chunk and resume, scramble pattern
    pat = 3; config_page(2'b00, 1, 0); base = gidx;
    start(0); send(300, acc);
    chk("R2 partial bytes", acc, 300);
    stop();
    chk("R2 stopped ready low", in_ready, 0);
    chk("R6 count before resume", ecc_cnt, 1);
    start(0); send(4096, acc2);
    chk("R4 remainder no loss", acc2, 1748);
    chk("R6 count after resume", ecc_cnt, 8);
    check_queue("R1 words across stop", 8, base);

    // R5: command write in mid chunk discards partial state
    pat = 0; config_page(2'b00, 0, 0);
    start(0); send(100, acc);
    cmd(0);
    chk("R5 cleared count", ecc_cnt, 0);
    base = gidx;
    send(4096, acc);
    chk("R5 remaining bytes", acc, 412);
    chk("R5 one word", ecc_cnt, 1);
    chk("R5 word after clear", ecc_head, exp_ecc(pat, base));

    // R7/R8/R9: automatic mode, read session, start at section 1
    pat = 3; config_page(2'b01, 1, 1);
    start(1); send(4096, acc);
    chk("R8 auto zone length", acc, 1536);
    chk("R7 spare requested", spare_req, 1);
    chk("R7 flow halted", in_ready, 0);
    chk("R8 spare zones", spare_zones, 3);
    @(negedge clk); mark_byte = 8'h00; #1;
    chk("R9 read check enabled", ecc_chk_en, 1);
    @(negedge clk); mark_byte = 8'h5A; #1;
    chk("R9 marker set blocks check", ecc_chk_en, 0);
    mark_byte = 8'h00;
    finish_spare();
    chk("R7 spare cleared count", ecc_cnt, 0);
    chk("R7 spare dropped", spare_req, 0);

    // R9: write session never enables checking
    pat = 2; config_page(2'b01, 0, 0);
    start(0); send(4096, acc);
    chk("R7 small auto length", acc, 512);
    chk("R8 small spare zones", spare_zones, 1);
    chk("R9 write session no check", ecc_chk_en, 0);
    finish_spare();

    // R10: reserved mode runs free
    pat = 1; config_page(2'b11, 1, 0);
    start(1); send(4096, acc);
    chk("R10 reserved length", acc, 2048);
    chk("R10 reserved no irq", ecc_rdy_irq, 0);
    chk("R10 reserved count", ecc_cnt, 8);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule